// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Status

The block receives asynchronous serial characters on one line. It takes 16 samples per bit, gated by an enable tick from an external rate generator. A start bit is accepted only if the line is still low at the middle of the bit. The block then shifts in 7, 8 or 9 data bits, least significant bit first, and checks an optional parity bit and the stop bit. When the frame is complete, the character moves into a 9-bit receive buffer in a single transfer, and a receive-complete pulse is raised for one cycle.

Three error flags report parity, framing and overrun conditions. Each flag is reloaded with the status of every character that lands in the buffer. A read strobe on the buffer clears all three flags. The shift register is internal and cannot be seen from outside. Only the buffer and the flags are visible. When reception is disabled, the receiver stays idle and the buffer is never written.

Top module: `uart_rx_status`

## Requirements
- R1: `rx_data` is 9 bits wide and holds the character least significant bit first. `char_len` selects the length: 00 gives 7 bits, 01 gives 8 bits, 10 or 11 gives 9 bits. Buffer bits above the character length read 0.
- R2: After reset, `rx_data` and all flags are 0. The buffer is written on the clock edge of the tick that samples the last stop bit. `rx_done` is high for exactly that following cycle. At all other times the buffer holds its value.
- R3: A low level seen on a tick in idle is accepted as a start bit only if the line is still low 8 ticks later. Otherwise the receiver returns to idle and transfers nothing.
- R4: `parity_mode` selects the parity bit: 00 means no parity bit, 01 means the bit must be 0, 10 means odd parity, 11 means even parity. A mismatch makes `err_parity` 1 when the character is transferred.
- R5: `err_frame` becomes 1 when the first stop bit samples low. With `two_stop` = 1, the transfer waits one more bit time, and the second stop bit is not checked.
- R6: If a character is transferred while the previous one has not been read, `err_overrun` becomes 1 and the new data overwrites the buffer.
- R7: A one-cycle `rd_strobe` clears all three flags and the unread state, and leaves `rx_data` unchanged.
- R8: At every transfer, each flag is reloaded from the new character. A flag left over from an earlier character is cleared, and it is set again if the new character has the same fault.
- R9: While `rx_en` is 0, the receiver is held idle, `rx_done` stays 0 and the buffer is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Reception enable |
| baud_tick | input | 1 | Enable at 16 times the bit rate |
| rxd | input | 1 | Serial receive line |
| char_len | input | 2 | Character length select |
| parity_mode | input | 2 | Parity mode select |
| two_stop | input | 1 | 1 selects two stop bits |
| rd_strobe | input | 1 | Buffer read strobe |
| rx_data | output | 9 | Receive buffer |
| rx_done | output | 1 | Receive-complete interrupt pulse |
| err_parity | output | 1 | Sticky parity error flag |
| err_frame | output | 1 | Sticky framing error flag |
| err_overrun | output | 1 | Sticky overrun flag |

## Verification
Characters are sent at all three lengths and in all four parity modes, so wrong bit alignment or a zero-padding fault shows up in the buffer value. Each frame type also lands on its own completion cycle, which exposes a wrong sample position or a wrong stop-bit count. Corrupted parity bits and low stop bits show whether each fault sets its own flag. Back-to-back characters without a read show whether the flags are reloaded and whether overrun is detected. A short low glitch, a frame sent while reception is disabled, and a low second stop bit each check that nothing is transferred, or that nothing is flagged, where nothing should be.

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic [1:0] char_len,
  input  logic [1:0] parity_mode,
  input  logic       two_stop,
  input  logic       rd_strobe,
  output logic [8:0] rx_data,
  output logic       rx_done,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun
);

  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP1, STOP2} state_t;

  state_t        st;
  logic [1:0]    sync;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [8:0]    sh;
  logic          ones, par_bad, frm_bad, full;

  wire       rxs     = sync[1];
  wire       at_bit  = baud_tick && (cnt == LAST);
  wire [3:0] nlen    = (char_len == 2'b00) ? 4'd7 : (char_len == 2'b01) ? 4'd8 : 4'd9;
  wire       p_x     = ones ^ rxs;
  wire       p_chk   = (parity_mode == 2'b01) ? rxs : (parity_mode == 2'b10) ? !p_x : p_x;
  wire       fin     = rx_en && at_bit && ((st == STOP1 && !two_stop) || st == STOP2);
  wire       stop_bad = (st == STOP1) ? !rxs : frm_bad;
  wire [8:0] aligned = (char_len == 2'b00) ? {2'b00, sh[8:2]} :
                       (char_len == 2'b01) ? {1'b0, sh[8:1]} : sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync        <= 2'b11;
      st          <= IDLE;
      cnt         <= '0;
      idx         <= '0;
      sh          <= '0;
      ones        <= 1'b0;
      par_bad     <= 1'b0;
      frm_bad     <= 1'b0;
      full        <= 1'b0;
      rx_data     <= '0;
      rx_done     <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      sync    <= {sync[0], rxd};
      rx_done <= fin;
      if (!rx_en) begin
        st  <= IDLE;
        cnt <= '0;
      end else if (baud_tick) begin
        case (st)
          IDLE: if (!rxs) begin
            st  <= START;
            cnt <= '0;
          end
          START: if (cnt == MID) begin
            cnt     <= '0;
            idx     <= '0;
            ones    <= 1'b0;
            par_bad <= 1'b0;
            st      <= rxs ? IDLE : DATA;
          end else cnt <= cnt + 1'b1;
          DATA: if (cnt == LAST) begin
            cnt  <= '0;
            sh   <= {rxs, sh[8:1]};
            ones <= p_x;
            idx  <= idx + 1'b1;
            if (idx == nlen - 4'd1) st <= (parity_mode == 2'b00) ? STOP1 : PAR;
          end else cnt <= cnt + 1'b1;
          PAR: if (cnt == LAST) begin
            cnt     <= '0;
            par_bad <= p_chk;
            st      <= STOP1;
          end else cnt <= cnt + 1'b1;
          STOP1: if (cnt == LAST) begin
            cnt     <= '0;
            frm_bad <= !rxs;
            st      <= two_stop ? STOP2 : IDLE;
          end else cnt <= cnt + 1'b1;
          STOP2: if (cnt == LAST) begin
            cnt <= '0;
            st  <= IDLE;
          end else cnt <= cnt + 1'b1;
          default: st <= IDLE;
        endcase
      end
      if (fin) begin
        rx_data     <= aligned;
        err_parity  <= par_bad;
        err_frame   <= stop_bad;
        err_overrun <= full;
        full        <= 1'b1;
      end else if (rd_strobe) begin
        err_parity  <= 1'b0;
        err_frame   <= 1'b0;
        err_overrun <= 1'b0;
        full        <= 1'b0;
      end
    end
  end

  a_r2_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  a_r2_buffer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(rx_data));

  a_r1_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !char_len[1]) |-> !rx_data[8]);

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_done);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !fin) |=> !(err_parity || err_frame || err_overrun));

  a_r6_overrun_on_unread: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && full) |=> err_overrun);

endmodule

// File: tb/uart_rx_status_bench.sv
module uart_rx_status_bench;
  logic clk = 0, rst_n = 0, rx_en = 0, baud_tick = 0, rxd = 1;
  logic [1:0] char_len = 0, parity_mode = 0;
  logic two_stop = 0, rd_strobe = 0;
  logic [8:0] rx_data;
  logic rx_done, err_parity, err_frame, err_overrun;

  int checks = 0, errors = 0, ndone = 0, exp_ndone = 0;
  bit run = 0;
  logic [8:0] exp_data = 0;
  bit exp_done = 0, exp_par = 0, exp_frm = 0, exp_ovr = 0, exp_full = 0;

  always #10 clk = ~clk;

  uart_rx_status u_uart_rx_status (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .baud_tick(baud_tick), .rxd(rxd),
    .char_len(char_len), .parity_mode(parity_mode), .two_stop(two_stop),
    .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_done(rx_done),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun));

  always @(posedge clk) if (rst_n && rx_done) ndone++;

  always @(negedge clk) if (run) begin
    checks++; if (rx_data !== exp_data) begin errors++; $display("FAIL R1 rx_data act=%h exp=%h", rx_data, exp_data); end
    checks++; if (rx_done !== exp_done) begin errors++; $display("FAIL R2 rx_done act=%b exp=%b", rx_done, exp_done); end
    checks++; if (err_parity !== exp_par) begin errors++; $display("FAIL R4 err_parity act=%b exp=%b", err_parity, exp_par); end
    checks++; if (err_frame !== exp_frm) begin errors++; $display("FAIL R5 err_frame act=%b exp=%b", err_frame, exp_frm); end
    checks++; if (err_overrun !== exp_ovr) begin errors++; $display("FAIL R6 err_overrun act=%b exp=%b", err_overrun, exp_ovr); end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic slot(bit fire, logic [8:0] d, bit p, bit f);
    baud_tick = 1;
    @(posedge clk); #1;
    if (fire) begin
      exp_data = d; exp_par = p; exp_frm = f; exp_ovr = exp_full;
      exp_full = 1; exp_done = 1; exp_ndone++;
    end
    @(negedge clk); baud_tick = 0;
    @(posedge clk); #1; exp_done = 0;
    @(negedge clk); @(negedge clk); @(negedge clk);
  endtask

  task automatic send(int d, int len, int pm, bit two, bit badp, bit stoplo, bit stop2lo);
    int n, np, ns, total, c;
    bit bits[14];
    logic [8:0] dm;
    char_len = len[1:0]; parity_mode = pm[1:0]; two_stop = two;
    n = (len == 0) ? 7 : (len == 1) ? 8 : 9;
    np = (pm != 0) ? 1 : 0;
    ns = two ? 2 : 1;
    dm = 9'(d & ((1 << n) - 1));
    bits[0] = 0;
    for (int i = 0; i < n; i++) bits[1+i] = dm[i];
    if (np == 1) bits[1+n] = ((pm == 1) ? 1'b0 : (pm == 2) ? ~^dm : ^dm) ^ badp;
    bits[1+n+np] = !stoplo;
    if (two) bits[2+n+np] = !stop2lo;
    total = 16 * (1 + n + np + ns);
    c = 9 + 16 * (n + np + ns);
    for (int s = 0; s < total; s++) begin
      rxd = bits[s/16];
      slot(rx_en && s == c, dm, badp && np == 1, stoplo);
    end
    rxd = 1;
    for (int s = 0; s < 16; s++) slot(0, 0, 0, 0);
  endtask

  task automatic read_buf();
    @(negedge clk); rd_strobe = 1;
    @(posedge clk); #1;
    exp_par = 0; exp_frm = 0; exp_ovr = 0; exp_full = 0;
    @(negedge clk); rd_strobe = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog act=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    run = 1;
    chk("R2 reset rx_data", int'(rx_data), 0);
    chk("R2 reset flags", int'({err_parity, err_frame, err_overrun}), 0);
    rx_en = 1;
    for (int s = 0; s < 4; s++) slot(0, 0, 0, 0);

    send(9'h0A5, 1, 0, 0, 0, 0, 0);
    chk("R1 8-bit no parity", int'(rx_data), 'hA5);
    read_buf();
    send(9'h1DA, 0, 3, 1, 0, 0, 0);
    chk("R1 7-bit top bits zero", int'(rx_data), 'h5A);
    read_buf();
    send(9'h1C3, 2, 2, 0, 0, 0, 0);
    chk("R1 9-bit odd parity", int'(rx_data), 'h1C3);
    read_buf();
    send(9'h03C, 1, 1, 0, 0, 0, 0);
    chk("R4 zero parity accepted", int'(err_parity), 0);
    read_buf();

    send(9'h055, 1, 3, 0, 1, 0, 0);
    chk("R4 even parity mismatch", int'(err_parity), 1);
    send(9'h066, 1, 3, 0, 0, 0, 0);
    chk("R8 parity flag reloaded clear", int'(err_parity), 0);
    chk("R6 overrun on unread", int'(err_overrun), 1);
    chk("R6 new data overwrites", int'(rx_data), 'h66);
    read_buf();
    chk("R7 read clears flags", int'({err_parity, err_frame, err_overrun}), 0);
    chk("R7 read keeps data", int'(rx_data), 'h66);

    send(9'h011, 1, 2, 0, 1, 0, 0);
    read_buf();
    send(9'h012, 1, 2, 0, 1, 0, 0);
    send(9'h013, 1, 2, 0, 1, 0, 0);
    chk("R8 parity flag set again", int'(err_parity), 1);
    read_buf();

    send(9'h07E, 1, 0, 0, 0, 1, 0);
    chk("R5 framing error", int'(err_frame), 1);
    chk("R3 false start after low stop no transfer", ndone, exp_ndone);
    read_buf();
    send(9'h081, 1, 0, 1, 0, 0, 1);
    chk("R5 second stop unchecked", int'(err_frame), 0);
    read_buf();

    rxd = 0;
    for (int s = 0; s < 4; s++) slot(0, 0, 0, 0);
    rxd = 1;
    for (int s = 0; s < 24; s++) slot(0, 0, 0, 0);
    chk("R3 glitch no transfer", ndone, exp_ndone);
    chk("R3 glitch buffer kept", int'(rx_data), 'h81);

    rx_en = 0;
    send(9'h0F0, 1, 0, 0, 0, 0, 0);
    chk("R9 disabled no pulse", ndone, exp_ndone);
    chk("R9 disabled buffer kept", int'(rx_data), 'h81);
    rx_en = 1;
    for (int s = 0; s < 2; s++) slot(0, 0, 0, 0);
    send(9'h100, 2, 0, 0, 0, 0, 0);
    chk("R1 9-bit msb", int'(rx_data), 'h100);
    chk("R2 pulse count", ndone, exp_ndone);

    run = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule